// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind a two-wire serial slave engine and in front of a byte-wide storage array. The engine has already decoded the bus. It tells the block when a write session opens and which byte address the master sent. It then strobes each data byte, and finally reports either the bus stop or a rejection. The block keeps the page part of the address fixed and fills a 16-entry staging buffer, with one valid bit per slot. The offset within the page advances after every byte and wraps inside the page.

When the stop arrives and at least one byte has been staged, the block enters a timed commit window of `TWR_CYC` clocks. During that window it drives the staged bytes into the array, one slot per clock. Slots that were never loaded are left alone. The busy output covers the whole window, and every request that arrives meanwhile is refused. The array is a register model that comes out of reset holding FFh in every byte. It has a combinational read port so that its contents can be seen.

The controller has three states. IDLE waits for a session. LOAD stages bytes. COMMIT is the timed write window. The transitions are:
- begin (IDLE to LOAD on `wr_begin`)
- restart (LOAD to LOAD on a second `wr_begin`, which drops staged data)
- discard (LOAD to IDLE on `abort_req`)
- empty-stop (LOAD to IDLE on `stop_seen` with nothing staged)
- commit (LOAD to COMMIT on `stop_seen` with data staged)
- done (COMMIT to IDLE after the last window cycle)

Top module: `pgbuf_commit`

## Requirements
- R1: On an accepted `wr_begin`, the upper `ADDR_W-4` bits of `wr_addr` select the page for the whole session, and the low 4 bits give the slot where the first data byte lands.
- R2: Each accepted byte goes to the current slot, and the slot then advances by one modulo 16 inside the same page. A byte sent to a slot loaded earlier in the session replaces the earlier byte.
- R3: Only a `stop_seen` moves staged bytes into the array. All slots loaded in the session are written in that one window, unloaded slots of the page keep their old contents, and no other page changes.
- R4: `busy` rises in the cycle after the clock edge that samples a `stop_seen` with data staged, and it stays high for exactly `TWR_CYC` cycles.
- R5: While `busy` is high, `wr_begin`, `byte_stb`, `abort_req` and `stop_seen` are ignored. They do not lengthen the window and they change no memory byte.
- R6: After reset every array byte reads FFh and `busy` is low.
- R7: `abort_req` during a session, or a second `wr_begin` before the stop, discards every staged byte. A discarded byte is never written.
- R8: A `stop_seen` with no byte staged (an address-only session) leaves `busy` low and writes nothing.
- R9: `mem_we` is asserted only while `busy` is high, and at most one byte is written per clock.
- R10: `byte_stb` or `stop_seen` outside a session (in IDLE) has no effect on the array or on `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_begin | input | 1 | Write session opens; `wr_addr` is valid |
| wr_addr | input | ADDR_W | Byte address sent by the master |
| byte_stb | input | 1 | One data byte is valid on `byte_data` |
| byte_data | input | DATA_W | Data byte to stage |
| abort_req | input | 1 | Rejection or repeated start: discard the session |
| stop_seen | input | 1 | Bus stop observed |
| busy | output | 1 | Commit window in progress; requests are refused |
| mem_we | output | 1 | Array write strobe |
| mem_waddr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array read data (combinational) |

## Verification
A wrong slot pointer or page latch shows as bytes in the wrong cell or the wrong page. This is visible on the read port as soon as the commit window closes, which is at most `TWR_CYC` cycles after the stop. A wrong valid mask either overwrites a neighbouring byte with stale buffer contents or drops a loaded byte, and both show up in the same full-array compare. A fault in the window counter or in the state register shows on `busy` at once: it rises on a refused or empty request, or it holds for a number of cycles other than `TWR_CYC`.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_COMMIT = 2'd2
    } pg_state_e;
endpackage

// File: rtl/pgbuf_ctrl.sv
module pgbuf_ctrl
    import pgbuf_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    parameter int TWR_CYC    = 20,
    parameter int OFS_W      = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_begin,
    input  logic             byte_stb,
    input  logic             abort_req,
    input  logic             stop_seen,
    input  logic             any_valid,
    output logic             take_addr,
    output logic             take_byte,
    output logic             clr_buf,
    output logic             busy,
    output logic             slot_go,
    output logic [OFS_W-1:0] slot_idx
);
    localparam int CW_A  = $clog2(TWR_CYC + 1);
    localparam int CNT_W = (CW_A > OFS_W + 1) ? CW_A : OFS_W + 1;
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(TWR_CYC - 1);
    localparam logic [CNT_W-1:0] SLOTS = CNT_W'(PAGE_BYTES);

    pg_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             last_cyc;

    assign last_cyc = (cnt_q == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (wr_begin) state_d = ST_LOAD;
            ST_LOAD: begin
                if (abort_req)      state_d = ST_IDLE;
                else if (stop_seen) state_d = any_valid ? ST_COMMIT : ST_IDLE;
            end
            ST_COMMIT: if (last_cyc) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // window counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (state_q == ST_COMMIT && state_d == ST_COMMIT)
            cnt_q <= cnt_q + 1'b1;
        else
            cnt_q <= '0;
    end

    // outputs
    always_comb begin
        take_addr = 1'b0;
        take_byte = 1'b0;
        clr_buf   = 1'b0;
        slot_go   = 1'b0;
        busy      = 1'b0;
        unique case (state_q)
            ST_IDLE:   take_addr = wr_begin;
            ST_LOAD: begin
                clr_buf   = abort_req | (stop_seen & ~any_valid);
                take_addr = ~abort_req & ~stop_seen & wr_begin;
                take_byte = ~abort_req & ~stop_seen & ~wr_begin & byte_stb;
            end
            ST_COMMIT: begin
                busy    = 1'b1;
                slot_go = (cnt_q < SLOTS);
                clr_buf = last_cyc;
            end
            default: ;
        endcase
    end

    assign slot_idx = cnt_q[OFS_W-1:0];

    // R4
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_seen));

    // R4
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(cnt_q) == LAST));

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT && !last_cyc) |=> (state_q == ST_COMMIT));

    // R8
    empty_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && stop_seen && !abort_req && !any_valid) |=> !busy);
endmodule

// File: rtl/pgbuf_store.sv
module pgbuf_store #(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16,
    parameter int OFS_W      = $clog2(PAGE_BYTES),
    parameter int PG_W       = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_addr,
    input  logic              take_byte,
    input  logic              clr_buf,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] byte_data,
    input  logic [OFS_W-1:0]  slot_idx,
    output logic              any_valid,
    output logic              slot_valid,
    output logic [DATA_W-1:0] slot_byte,
    output logic [PG_W-1:0]   page_q
);
    logic [PAGE_BYTES-1:0] mask_q;
    logic [OFS_W-1:0]      ofs_q;
    logic [DATA_W-1:0]     slot_q [PAGE_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            ofs_q  <= '0;
            page_q <= '0;
        end else if (clr_buf) begin
            mask_q <= '0;
        end else if (take_addr) begin
            mask_q <= '0;
            page_q <= wr_addr[ADDR_W-1:OFS_W];
            ofs_q  <= wr_addr[OFS_W-1:0];
        end else if (take_byte) begin
            mask_q[ofs_q] <= 1'b1;
            ofs_q         <= ofs_q + 1'b1;
        end
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (take_byte && ofs_q == OFS_W'(g))
                slot_q[g] <= byte_data;
        end
    end

    assign any_valid  = |mask_q;
    assign slot_valid = mask_q[slot_idx];
    assign slot_byte  = slot_q[slot_idx];

    // R2
    slot_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_byte && !clr_buf) |=> mask_q[$past(ofs_q)]);

    // R7
    discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_buf |=> (mask_q == '0));
endmodule

// File: rtl/pgbuf_array.sv
module pgbuf_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cell_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= '1;
        end else if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/pgbuf_commit.sv
module pgbuf_commit #(
    parameter int ADDR_W  = 11,
    parameter int DATA_W  = 8,
    parameter int TWR_CYC = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_begin,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              abort_req,
    input  logic              stop_seen,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PAGE_BYTES = 16;
    localparam int OFS_W      = $clog2(PAGE_BYTES);
    localparam int PG_W       = ADDR_W - OFS_W;

    logic             take_addr, take_byte, clr_buf, slot_go, any_valid, slot_valid;
    logic [OFS_W-1:0] slot_idx;
    logic [DATA_W-1:0] slot_byte;
    logic [PG_W-1:0]  page_q;

    pgbuf_ctrl #(.PAGE_BYTES(PAGE_BYTES), .TWR_CYC(TWR_CYC), .OFS_W(OFS_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_begin(wr_begin), .byte_stb(byte_stb),
        .abort_req(abort_req), .stop_seen(stop_seen), .any_valid(any_valid),
        .take_addr(take_addr), .take_byte(take_byte), .clr_buf(clr_buf),
        .busy(busy), .slot_go(slot_go), .slot_idx(slot_idx)
    );

    pgbuf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES),
                  .OFS_W(OFS_W), .PG_W(PG_W)) u_store (
        .clk(clk), .rst_n(rst_n), .take_addr(take_addr), .take_byte(take_byte),
        .clr_buf(clr_buf), .wr_addr(wr_addr), .byte_data(byte_data),
        .slot_idx(slot_idx), .any_valid(any_valid), .slot_valid(slot_valid),
        .slot_byte(slot_byte), .page_q(page_q)
    );

    assign mem_we    = slot_go & slot_valid;
    assign mem_waddr = {page_q, slot_idx};
    assign mem_wdata = slot_byte;

    pgbuf_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr),
        .wdata(mem_wdata), .raddr(rd_addr), .rdata(rd_data)
    );

    // R9
    we_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R3
    page_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(page_q));
endmodule

// File: tb/pgbuf_commit_bench.sv
module pgbuf_commit_bench;
    localparam int AW    = 6;
    localparam int DW    = 8;
    localparam int TWR   = 20;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_begin = 1'b0, byte_stb = 1'b0, abort_req = 1'b0, stop_seen = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] byte_data = '0;
    logic          busy, mem_we;
    logic [AW-1:0] mem_waddr;
    logic [DW-1:0] mem_wdata, rd_data;

    always #2.5 clk = ~clk;

    pgbuf_commit #(.ADDR_W(AW), .DATA_W(DW), .TWR_CYC(TWR)) u_pgbuf_commit (
        .clk(clk), .rst_n(rst_n), .wr_begin(wr_begin), .wr_addr(wr_addr),
        .byte_stb(byte_stb), .byte_data(byte_data), .abort_req(abort_req),
        .stop_seen(stop_seen), .busy(busy), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    int checks = 0, errors = 0, cyc = 0, stop_cyc = 0, exp_len = 0;
    bit finished = 0;

    logic [DW-1:0] ref_mem [DEPTH];
    logic [DW-1:0] m_buf [16];
    bit            m_val [16];
    bit            m_active = 0, m_busy = 0;
    int            m_page = 0, m_ofs = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
    endtask

    task automatic t_begin(input int a);
        wr_begin = 1'b1; wr_addr = AW'(a);
        tick();
        wr_begin = 1'b0;
        if (!m_busy) begin
            m_active = 1; m_page = a / 16; m_ofs = a % 16;
            for (int i = 0; i < 16; i++) m_val[i] = 0;
        end
    endtask

    task automatic t_byte(input int d);
        byte_stb = 1'b1; byte_data = DW'(d);
        tick();
        byte_stb = 1'b0;
        if (!m_busy && m_active) begin
            m_buf[m_ofs] = DW'(d); m_val[m_ofs] = 1; m_ofs = (m_ofs + 1) % 16;
        end
    endtask

    task automatic t_abort();
        abort_req = 1'b1;
        tick();
        abort_req = 1'b0;
        if (!m_busy) begin
            m_active = 0;
            for (int i = 0; i < 16; i++) m_val[i] = 0;
        end
    endtask

    task automatic t_stop();
        bit any;
        stop_seen = 1'b1;
        tick();
        stop_seen = 1'b0;
        if (!m_busy) begin
            any = 0;
            for (int i = 0; i < 16; i++) any |= m_val[i];
            exp_len = 0;
            if (m_active && any) begin
                for (int i = 0; i < 16; i++)
                    if (m_val[i]) ref_mem[m_page*16 + i] = m_buf[i];
                m_busy = 1; exp_len = TWR; stop_cyc = cyc;
            end
            m_active = 0;
            for (int i = 0; i < 16; i++) m_val[i] = 0;
        end
    endtask

    task automatic t_finish(input string req);
        int n = 0;
        int remain;
        remain = m_busy ? TWR - (cyc - stop_cyc) : 0;
        while (busy && n < TWR + 8) begin
            n++;
            tick();
        end
        check(n == remain, req, n, remain);
        m_busy = 0;
    endtask

    task automatic cmp_all(input string req);
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = AW'(a);
            #0.1;
            check(rd_data === ref_mem[a], req, int'(rd_data), int'(ref_mem[a]));
        end
    endtask

    initial begin
        for (int a = 0; a < DEPTH; a++) ref_mem[a] = 8'hFF;
        for (int i = 0; i < 16; i++) begin m_val[i] = 0; m_buf[i] = '0; end
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R6: reset state
        check(busy == 1'b0, "R6 busy", busy, 0);
        cmp_all("R6 erased");

        // R10: strobes outside a session
        t_byte(8'h3C); t_stop(); t_finish("R10 busy");
        cmp_all("R10 array");

        // R1 R3 R4: single byte
        t_begin(6'h13); t_byte(8'hA5); t_stop(); t_finish("R4 window");
        cmp_all("R1 R3 single");

        // R2: 20 bytes from slot 13 wrap inside page 2
        t_begin(6'h2D);
        for (int k = 0; k < 20; k++) t_byte(8'h40 + k);
        t_stop(); t_finish("R4 window");
        cmp_all("R2 wrap");

        // R7: abort discards
        t_begin(6'h05); t_byte(8'h01); t_byte(8'h02); t_byte(8'h03);
        t_abort(); t_stop(); t_finish("R7 busy");
        cmp_all("R7 abort");

        // R7: second begin discards staged bytes
        t_begin(6'h10); t_byte(8'h77); t_begin(6'h1A); t_byte(8'h66);
        t_stop(); t_finish("R7 window");
        cmp_all("R7 restart");

        // R8: address-only session
        t_begin(6'h30); t_stop(); t_finish("R8 busy");
        cmp_all("R8 array");

        // R5: requests during the window are refused
        t_begin(6'h08); t_byte(8'h11); t_stop();
        check(busy == 1'b1, "R5 busy", busy, 1);
        t_begin(6'h20); t_byte(8'h99); t_abort(); t_stop();
        t_begin(6'h21); t_byte(8'h98);
        t_finish("R5 window");
        cmp_all("R5 refused");

        // R1 R2 R3: sweep over every page and start slot
        for (int p = 0; p < DEPTH / 16; p++) begin
            for (int s = 0; s < 16; s++) begin
                t_begin(p*16 + s);
                for (int k = 0; k < (s % 5) + 1 + (p == 3 ? 14 : 0); k++)
                    t_byte((p*37 + s*11 + k*3) & 8'hFF);
                t_stop(); t_finish("R4 sweep");
                cmp_all("R3 sweep");
            end
        end

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule